// File: doc/BRIEF.md
# I2C Slave Receiver with Status Codes

This block is the receive side of an I2C slave. It passes SCL and SDA through a synchronizer and detects START and STOP. After a START it compares the address byte with a 7-bit own address that carries a write bit, or with the general call address. It then takes in data bytes and answers each one with ACK or NACK, depending on an acknowledge-enable input that the host controls.

Every bus event that matters is reported to the host as a fixed 8-bit status code. With the code, the block raises an interrupt flag and holds SCL low. The bus stays stalled until the host clears the flag with a one-cycle pulse. Before clearing, the host chooses what happens next through the acknowledge-enable input. The last received byte stays readable on a data output.

Both I2C lines are open drain. Each one is modelled as an output-enable that pulls the wire low when it is 1.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, `flag` is 0, `status` is 0xF8, and both `scl_oe` and `sda_oe` are 0. Whenever `flag` is 0, `status` reads 0xF8.
- R2: When the address byte equals `{own_addr, 1'b0}` and `ack_en` is 1, the slave pulls SDA low in the ninth clock. When that clock falls, `status` becomes 0x60 and `flag` is set.
- R3: The address byte 0x00 is acknowledged only when both `gc_en` and `ack_en` are 1, and it posts 0x70. A data byte received after a general call posts 0x90 when ACKed and 0x98 when NACKed. With `gc_en` equal to 0, the address byte 0x00 gets no ACK and no flag.
- R4: An address byte whose bit 0 is 1 (read), or whose upper 7 bits differ from `own_addr`, gets no ACK and no flag. Data bytes that follow it are ignored.
- R5: While `ack_en` is 0, the own address is not acknowledged. Once `ack_en` is back at 1, the address is recognized again after the next START.
- R6: A data byte received after the own address is placed on `rx_data`. It posts 0x80 with ACK when `ack_en` is 1 and 0x88 with NACK (SDA released) when `ack_en` is 0. `ack_en` is sampled when the eighth data bit ends.
- R7: While `flag` is 1, `scl_oe` is 1 and `status` and `rx_data` stay stable. A one-cycle `flag_clr` pulse clears `flag` on the next cycle and `status` returns to 0xF8.
- R8: After the host clears a 0x88 or 0x98 code, the slave is not addressed. Further bytes get no ACK and no flag until a START arrives with a matching address.
- R9: If `arb_lost` is 1 when a matching address byte ends, the code posted is 0x68 instead of 0x60, or 0x78 instead of 0x70.
- R10: A STOP or a repeated START while the slave is addressed posts 0xA0. After the clear, a STOP leaves the slave idle. A repeated START lets the next address byte be matched at once.
- R11: Bytes are shifted in MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pulls SCL low (clock stretch) |
| sda_oe | output | 1 | Pulls SDA low (ACK) |
| own_addr | input | ADDR_W | Own slave address |
| gc_en | input | 1 | General call recognition enable |
| ack_en | input | 1 | Acknowledge enable |
| arb_lost | input | 1 | The master side lost arbitration; selects the alternate address codes |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| rx_data | output | ADDR_W+1 | Last received data byte |

## Verification
The host's control decisions and the bus's byte boundaries can land on the same cycle. One case is `ack_en` or `arb_lost` changing just as the eighth bit of a byte ends, where the ACK decision is taken. Another is the flag clear releasing SCL just as the master resumes clocking. The bench changes `ack_en`, `gc_en` and `arb_lost` at random right before each byte and clears the flag right before the next bit. It judges each byte by the ACK bit the master samples in the ninth clock and by the status code predicted from the values set before that byte. Directed cases also place a STOP and a repeated START directly after an acknowledged byte.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    localparam logic [7:0] CODE_NONE     = 8'hF8;
    localparam logic [7:0] CODE_OWN      = 8'h60;
    localparam logic [7:0] CODE_OWN_ARB  = 8'h68;
    localparam logic [7:0] CODE_GC       = 8'h70;
    localparam logic [7:0] CODE_GC_ARB   = 8'h78;
    localparam logic [7:0] CODE_DAT_ACK  = 8'h80;
    localparam logic [7:0] CODE_DAT_NACK = 8'h88;
    localparam logic [7:0] CODE_GCD_ACK  = 8'h90;
    localparam logic [7:0] CODE_GCD_NACK = 8'h98;
    localparam logic [7:0] CODE_STOP_RS  = 8'hA0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_WAIT
    } rx_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_s, sda_s, scl_p_q, sda_p_q;

    i2c_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst_n(rst_n), .d(scl_raw), .q(scl_s));
    i2c_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst_n(rst_n), .d(sda_raw), .q(sda_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign sda_bit  = sda_s;
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              arb_lost,
    input  logic              flag_clr,
    output logic              flag,
    output logic [7:0]        status,
    output logic [ADDR_W:0]   rx_data
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        rx_state_e         st;
        rx_state_e         resume;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              flag;
        logic [7:0]        status;
        logic [7:0]        pend;
        logic [BYTE_W-1:0] rx;
        logic              gc;
        logic              sda_oe;
        logic              nack;
    } regs_t;

    regs_t r_q, r_d;
    logic  sda_bit, scl_rise, scl_fall, start_ev, stop_ev;
    logic  own_hit, gc_hit, addressed;

    i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign own_hit   = (r_q.sh[BYTE_W-1:1] == own_addr) && !r_q.sh[0];
    assign gc_hit    = (r_q.sh == '0) && gc_en;
    assign addressed = (r_q.st == ST_AACK) || (r_q.st == ST_DATA) || (r_q.st == ST_DACK);

    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_WAIT) begin
            if (flag_clr) begin
                r_d.flag   = 1'b0;
                r_d.status = CODE_NONE;
                r_d.st     = r_q.resume;
                r_d.cnt    = '0;
            end
        end else if (start_ev || stop_ev) begin
            r_d.sda_oe = 1'b0;
            r_d.cnt    = '0;
            if (addressed) begin
                r_d.flag   = 1'b1;
                r_d.status = CODE_STOP_RS;
                r_d.st     = ST_WAIT;
                r_d.resume = start_ev ? ST_ADDR : ST_IDLE;
            end else begin
                r_d.st = start_ev ? ST_ADDR : ST_IDLE;
            end
        end else begin
            case (r_q.st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && (r_q.cnt != CNT_W'(BYTE_W))) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_bit};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && (r_q.cnt == CNT_W'(BYTE_W))) begin
                        if (r_q.st == ST_ADDR) begin
                            if (ack_en && (own_hit || gc_hit)) begin
                                r_d.sda_oe = 1'b1;
                                r_d.gc     = !own_hit;
                                r_d.st     = ST_AACK;
                                if (own_hit) r_d.pend = arb_lost ? CODE_OWN_ARB : CODE_OWN;
                                else         r_d.pend = arb_lost ? CODE_GC_ARB : CODE_GC;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else begin
                            r_d.rx     = r_q.sh;
                            r_d.nack   = !ack_en;
                            r_d.sda_oe = ack_en;
                            r_d.st     = ST_DACK;
                            if (r_q.gc) r_d.pend = ack_en ? CODE_GCD_ACK : CODE_GCD_NACK;
                            else        r_d.pend = ack_en ? CODE_DAT_ACK : CODE_DAT_NACK;
                        end
                    end
                end
                ST_AACK, ST_DACK: begin
                    if (scl_fall) begin
                        r_d.sda_oe = 1'b0;
                        r_d.flag   = 1'b1;
                        r_d.status = r_q.pend;
                        r_d.st     = ST_WAIT;
                        r_d.cnt    = '0;
                        r_d.resume = (r_q.st == ST_DACK && r_q.nack) ? ST_IDLE : ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.resume <= ST_IDLE;
            r_q.status <= CODE_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe  = r_q.flag;
    assign sda_oe  = r_q.sda_oe;
    assign flag    = r_q.flag;
    assign status  = r_q.status;
    assign rx_data = r_q.rx;
endmodule

// File: rtl/i2c_rx_slave_chk.sv
module i2c_rx_slave_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag,
    input logic              flag_clr,
    input logic              scl_oe,
    input logic [7:0]        status,
    input logic [BYTE_W-1:0] rx_data
);
    AST_STRETCH_WHILE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> scl_oe);                                          // R7
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> status == 8'hF8);                                // R1
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && flag_clr) |=> !flag);                             // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> $stable(status) && $stable(rx_data)); // R7
    AST_POST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> status != 8'hF8);                          // R2
endmodule

bind i2c_rx_slave i2c_rx_slave_chk #(.BYTE_W(ADDR_W + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag(flag), .flag_clr(flag_clr),
    .scl_oe(scl_oe), .status(status), .rx_data(rx_data)
);

// File: tb/sim_i2c_rx_slave.sv
`timescale 1ns/1ps
module sim_i2c_rx_slave;
    localparam int H = 10;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic gc_en = 1'b0, ack_en = 1'b1, arb_lost = 1'b0, flag_clr = 1'b0;
    logic scl_oe, sda_oe, flag;
    logic [7:0] status, rx_data;
    wire  scl_line = scl_m & ~scl_oe;
    wire  sda_line = sda_m & ~sda_oe;
    int   errors = 0, checks = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    i2c_rx_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .gc_en(gc_en),
        .ack_en(ack_en), .arb_lost(arb_lost), .flag_clr(flag_clr),
        .flag(flag), .status(status), .rx_data(rx_data)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic raise_scl();
        scl_m = 1'b1;
        while (scl_line == 1'b0) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        wait_cyc(H);
        raise_scl();
        wait_cyc(H);
        scl_m = 1'b0;
        wait_cyc(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1;
        wait_cyc(H);
        raise_scl();
        wait_cyc(H / 2);
        ack = !sda_line;
        wait_cyc(H / 2);
        scl_m = 1'b0;
        wait_cyc(9);
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        wait_cyc(H);
        raise_scl();
        wait_cyc(H);
        sda_m = 1'b0;
        wait_cyc(H);
        scl_m = 1'b0;
        wait_cyc(3);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        wait_cyc(H);
        raise_scl();
        wait_cyc(H);
        sda_m = 1'b1;
        wait_cyc(H);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        wait_cyc(1);
        flag_clr = 1'b0;
        wait_cyc(2);
    endtask

    function automatic logic [7:0] exp_addr(input logic [7:0] a, input logic ae,
                                            input logic ge, input logic arb);
        if (!ae) return 8'hFF;
        if (a[7:1] == OWN && !a[0]) return arb ? 8'h68 : 8'h60;
        if (a == 8'h00 && ge) return arb ? 8'h78 : 8'h70;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_data(input logic gc, input logic ae);
        if (gc) return ae ? 8'h90 : 8'h98;
        return ae ? 8'h80 : 8'h88;
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic ack;
        logic [7:0] e;
        void'($urandom(32'd4711));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1: reset state
        chk("R1 flag", {7'b0, flag}, 8'h00);
        chk("R1 status", status, 8'hF8);
        chk("R1 oe", {6'b0, scl_oe, sda_oe}, 8'h00);

        // R2, R7, R6, R11, R8
        do_start();
        send_byte({OWN, 1'b0}, ack);
        chk("R2 ack", {7'b0, ack}, 8'h01);
        chk("R2 status", status, 8'h60);
        chk("R7 scl held", {7'b0, scl_line}, 8'h00);
        clear_flag();
        chk("R7 cleared", {7'b0, flag}, 8'h00);
        chk("R7 status", status, 8'hF8);
        send_byte(8'hC4, ack);
        chk("R6 ack", {7'b0, ack}, 8'h01);
        chk("R6 status", status, 8'h80);
        chk("R11 msb first", rx_data, 8'hC4);
        clear_flag();
        ack_en = 1'b0;
        send_byte(8'h3B, ack);
        chk("R6 nack", {7'b0, ack}, 8'h00);
        chk("R6 status nack", status, 8'h88);
        chk("R6 data", rx_data, 8'h3B);
        clear_flag();
        ack_en = 1'b1;
        send_byte(8'h55, ack);
        chk("R8 no ack", {7'b0, ack}, 8'h00);
        chk("R8 no flag", {7'b0, flag}, 8'h00);
        do_stop();
        chk("R8 stop silent", {7'b0, flag}, 8'h00);

        // R4: read bit and foreign address
        do_start();
        send_byte({OWN, 1'b1}, ack);
        chk("R4 read ack", {7'b0, ack}, 8'h00);
        chk("R4 read flag", {7'b0, flag}, 8'h00);
        do_start();
        send_byte({OWN ^ 7'h01, 1'b0}, ack);
        chk("R4 other ack", {7'b0, ack}, 8'h00);
        send_byte(8'h77, ack);
        chk("R4 data ignored", {7'b0, ack | flag}, 8'h00);
        do_stop();

        // R5: acknowledge disabled, then re-enabled
        ack_en = 1'b0;
        do_start();
        send_byte({OWN, 1'b0}, ack);
        chk("R5 no ack", {7'b0, ack | flag}, 8'h00);
        ack_en = 1'b1;
        do_start();
        send_byte({OWN, 1'b0}, ack);
        chk("R5 resumed", status, 8'h60);
        clear_flag();
        do_stop();
        chk("R10 stop", status, 8'hA0);
        clear_flag();
        chk("R10 idle", status, 8'hF8);

        // R3: general call
        do_start();
        send_byte(8'h00, ack);
        chk("R3 gc off", {7'b0, ack | flag}, 8'h00);
        gc_en = 1'b1;
        do_start();
        send_byte(8'h00, ack);
        chk("R3 gc ack", {7'b0, ack}, 8'h01);
        chk("R3 gc status", status, 8'h70);
        clear_flag();
        send_byte(8'h9E, ack);
        chk("R3 gc data", status, 8'h90);
        clear_flag();
        // R10: repeated start while addressed
        do_start();
        chk("R10 rep start", status, 8'hA0);
        clear_flag();
        // R9: arbitration-lost variants
        arb_lost = 1'b1;
        send_byte({OWN, 1'b0}, ack);
        chk("R9 own arb", status, 8'h68);
        clear_flag();
        do_start();
        chk("R10 rep start 2", status, 8'hA0);
        clear_flag();
        send_byte(8'h00, ack);
        chk("R9 gc arb", status, 8'h78);
        clear_flag();
        arb_lost = 1'b0;
        ack_en = 1'b0;
        send_byte(8'h12, ack);
        chk("R3 gc nack", status, 8'h98);
        clear_flag();
        ack_en = 1'b1;
        do_stop();
        chk("R8 after gc nack", {7'b0, flag}, 8'h00);

        // random transactions
        for (int t = 0; t < 40; t++) begin
            logic [7:0] a;
            logic       gc_sel;
            logic       alive;
            int         sel = $urandom % 4;
            a = (sel < 2) ? {OWN, 1'b0} : (sel == 2) ? 8'h00 : 8'($urandom);
            gc_en = 1'($urandom);
            ack_en = ($urandom % 4) != 0;
            arb_lost = 1'($urandom);
            e = exp_addr(a, ack_en, gc_en, arb_lost);
            gc_sel = (a == 8'h00) && !(a[7:1] == OWN);
            do_start();
            send_byte(a, ack);
            if (e == 8'hFF) begin
                chk("R4 rnd no ack", {7'b0, ack | flag}, 8'h00);
                send_byte(8'($urandom), ack);
                chk("R4 rnd ignored", {7'b0, ack | flag}, 8'h00);
                do_stop();
                chk("R4 rnd stop", {7'b0, flag}, 8'h00);
            end else begin
                chk("R2 rnd addr", status, e);
                chk("R2 rnd ack", {7'b0, ack}, 8'h01);
                clear_flag();
                alive = 1'b1;
                for (int b = 0; b < 1 + int'($urandom % 3); b++) begin
                    logic [7:0] d = 8'($urandom);
                    if (alive) begin
                        ack_en = ($urandom % 3) != 0;
                        send_byte(d, ack);
                        chk("R6 rnd code", status, exp_data(gc_sel, ack_en));
                        chk("R6 rnd ack", {7'b0, ack}, {7'b0, ack_en});
                        chk("R11 rnd data", rx_data, d);
                        clear_flag();
                        if (!ack_en) alive = 1'b0;
                    end
                end
                do_stop();
                if (alive) begin
                    chk("R10 rnd stop", status, 8'hA0);
                    clear_flag();
                end else begin
                    chk("R8 rnd stop", {7'b0, flag}, 8'h00);
                end
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule